// File: doc/BRIEF.md
# Seconds Counter Register Core

This block keeps an elapsed-seconds count for a timekeeping device. A free-running reference at 32.768 kHz arrives as a one-cycle tick strobe. A binary prescaler divides it down to a one-second enable, and that enable advances a 32-bit counter. Software turns the count into calendar time; the block does no such conversion.

The counter, a control byte and a trickle-charge configuration byte form a six-byte register space. A serial bus front end reaches this space through a simple byte-wide port. The port has a strobe, a direction, a 3-bit address, write data and registered read data. When the supply monitor reports that main power is low, the port is locked out. The counter keeps running while the port is locked.

The trickle-charge byte is decoded into enable, diode-select and resistor-select outputs. The enable becomes active only when a 4-bit key and valid selections are present.

Top module: `secs_reg_core`

## Requirements
- R1: With control bit 7 clear, the counter increments by one on every 2**PRESCALE_W-th accepted tick (32768 by default), and carries propagate through all 32 bits.
- R2: The counter is little-endian. Address 00h holds bits 7:0, 01h holds 15:8, 02h holds 23:16 and 03h holds 31:24. A write to one of these addresses replaces only that byte.
- R3: While control bit 7 (address 04h) is 1, neither the counter nor the prescaler advances. When the bit returns to 0, counting resumes from the held prescaler phase. The whole control byte reads back as written.
- R4: A read of 00h returns the live low byte and captures bits 31:8 in a snapshot. Reads of 01h to 03h return the snapshot, so a carry between reads cannot tear the value.
- R5: Any write to 00h–03h clears the prescaler, so the next increment comes a full 2**PRESCALE_W ticks later.
- R6: After reset, the counter, the control byte, the trickle byte and rdata_o are all zero, and chg_en_o is 0.
- R7: chg_en_o is 1 only when all three conditions hold: trickle bits 7:4 are 1010b, bits 3:2 are 01b (no diode) or 10b (one diode), and bits 1:0 are not 00b. chg_diode_o is 1 exactly when bits 3:2 are 10b. chg_res_o equals bits 1:0.
- R8: While pwr_fail_i is 1, writes are ignored and reads return 00h. The counter still counts.
- R9: Addresses 06h and 07h read as 00h, and writes to them change nothing.
- R10: Read data appears on rdata_o one cycle after the read strobe and holds until the next accepted or blocked read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per 32.768 kHz reference period |
| pwr_fail_i | input | 1 | Main power below trip point; locks the register port |
| acc_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| chg_en_o | output | 1 | Trickle charge enable |
| chg_diode_o | output | 1 | 1 = diode in charge path |
| chg_res_o | output | 2 | Resistor select code |

## Verification
The bench builds the core with PRESCALE_W = 3, so one second takes eight ticks. This short second makes several things practical to test with precise tick counts: carries across all four bytes, the prescaler-clear window, the prescaler hold while the oscillator-disable bit is set, and snapshot tearing. The counter width stays at 32, so the byte map is the real one. The trickle-charge decode is swept over all 256 register values and compared with an arithmetic model.

// File: rtl/secs_pkg.sv
package secs_pkg;
  localparam logic [3:0] CHG_KEY = 4'b1010;

  typedef struct packed {
    logic [3:0] key;
    logic [1:0] diode;
    logic [1:0] res;
  } trk_cfg_t;
endpackage

// File: rtl/sec_prescaler.sv
module sec_prescaler #(
  parameter int unsigned W = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic clear_i,
  output logic sec_o
);
  logic [W-1:0] cnt_q;

  assign sec_o = run_i && tick_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clear_i)        cnt_q <= '0;
    else if (run_i && tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sec_counter.sv
module sec_counter #(
  parameter int unsigned CNT_W = 32,
  localparam int unsigned NB = CNT_W / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic [NB-1:0]    byte_we_i,
  input  logic [7:0]       wdata_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // write wins over increment; prescaler is cleared on write anyway
  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_comb begin
      if (byte_we_i[b])     cnt_d[b*8 +: 8] = wdata_i;
      else if (|byte_we_i)  cnt_d[b*8 +: 8] = cnt_q[b*8 +: 8];
      else                  cnt_d[b*8 +: 8] = (cnt_q + CNT_W'(inc_i)) >> (b*8);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/trickle_decode.sv
module trickle_decode
  import secs_pkg::*;
(
  input  trk_cfg_t   cfg_i,
  output logic       en_o,
  output logic       diode_o,
  output logic [1:0] res_o
);
  logic diode_ok;

  assign diode_ok = (cfg_i.diode == 2'b01) || (cfg_i.diode == 2'b10);
  assign en_o     = (cfg_i.key == CHG_KEY) && diode_ok && (cfg_i.res != 2'b00);
  assign diode_o  = (cfg_i.diode == 2'b10);
  assign res_o    = cfg_i.res;
endmodule

// File: rtl/secs_reg_core.sv
module secs_reg_core
  import secs_pkg::*;
#(
  parameter int unsigned PRESCALE_W = 15,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned ADDR_W     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pwr_fail_i,
  input  logic              acc_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              chg_en_o,
  output logic              chg_diode_o,
  output logic [1:0]        chg_res_o
);
  localparam int unsigned NB       = CNT_W / 8;
  localparam int unsigned CTRL_ADR = NB;
  localparam int unsigned TRK_ADR  = NB + 1;

  logic             wr_ok, rd_ok, sec, run, cnt_wr;
  logic [NB-1:0]    byte_we;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-9:0] snap_q;
  logic [7:0]       ctrl_q, rd_byte;
  trk_cfg_t         trk_q;

  assign wr_ok  = acc_i && wr_i && !pwr_fail_i;
  assign rd_ok  = acc_i && !wr_i && !pwr_fail_i;
  assign run    = !ctrl_q[7];

  for (genvar b = 0; b < NB; b++) begin : g_we
    assign byte_we[b] = wr_ok && (addr_i == ADDR_W'(b));
  end
  assign cnt_wr = |byte_we;

  sec_prescaler #(.W(PRESCALE_W)) u_presc (
    .clk_i, .rst_ni, .tick_i, .run_i(run), .clear_i(cnt_wr), .sec_o(sec)
  );

  sec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .inc_i(sec), .byte_we_i(byte_we), .wdata_i, .cnt_o(cnt_q)
  );

  trickle_decode u_trk (
    .cfg_i(trk_q), .en_o(chg_en_o), .diode_o(chg_diode_o), .res_o(chg_res_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      trk_q  <= '0;
    end else if (wr_ok) begin
      if (addr_i == ADDR_W'(CTRL_ADR)) ctrl_q <= wdata_i;
      if (addr_i == ADDR_W'(TRK_ADR))  trk_q  <= trk_cfg_t'(wdata_i);
    end
  end

  always_comb begin
    rd_byte = '0;
    if (addr_i == '0) rd_byte = cnt_q[7:0];
    for (int k = 1; k < NB; k++)
      if (addr_i == ADDR_W'(k)) rd_byte = snap_q[(k-1)*8 +: 8];
    if (addr_i == ADDR_W'(CTRL_ADR)) rd_byte = ctrl_q;
    if (addr_i == ADDR_W'(TRK_ADR))  rd_byte = trk_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      snap_q  <= '0;
    end else if (acc_i && !wr_i) begin
      rdata_o <= rd_ok ? rd_byte : 8'h00;
      if (rd_ok && addr_i == '0) snap_q <= cnt_q[CNT_W-1:8];
    end
  end
endmodule

// File: rtl/secs_reg_core_chk.sv
module secs_reg_core_chk #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwr_fail_i,
  input logic              acc_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        rdata_o,
  input logic              chg_en_o,
  input logic [1:0]        chg_res_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [7:0]        ctrl_q,
  input logic [7:0]        trk_q
);
  localparam int unsigned NB = CNT_W / 8;
  logic cnt_wr;
  assign cnt_wr = acc_i && wr_i && !pwr_fail_i && (addr_i < ADDR_W'(NB));

  // R3
  osc_off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[7] && !cnt_wr) |=> $stable(cnt_q));

  // R1
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_wr |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

  // R8
  locked_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |=> $stable(ctrl_q) && $stable(trk_q));

  // R8
  locked_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_fail_i && acc_i && !wr_i) |=> rdata_o == 8'h00);

  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_i && !wr_i) |=> $stable(rdata_o));

  // R7
  chg_res_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_en_o |-> (chg_res_o != 2'b00) && (trk_q[7:4] == 4'b1010));
endmodule

bind secs_reg_core secs_reg_core_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_fail_i(pwr_fail_i), .acc_i(acc_i),
  .wr_i(wr_i), .addr_i(addr_i), .rdata_o(rdata_o), .chg_en_o(chg_en_o),
  .chg_res_o(chg_res_o), .cnt_q(cnt_q), .ctrl_q(ctrl_q), .trk_q(trk_q)
);

// File: tb/test_secs_reg_core.sv
module test_secs_reg_core;
  localparam int unsigned PW  = 3;
  localparam int unsigned SEC = 2 ** PW;

  logic clk = 0, rst_ni = 0, tick_i = 0, pwr_fail_i = 0, acc_i = 0, wr_i = 0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic chg_en_o, chg_diode_o;
  logic [1:0] chg_res_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_cnt = 0;
  logic [23:0] m_snap = 0;
  logic [7:0]  m_ctrl = 0, m_trk = 0;
  int m_pre = 0;

  always #2 clk = ~clk;

  secs_reg_core #(.PRESCALE_W(PW)) i_secs_reg_core (
    .clk_i(clk), .rst_ni, .tick_i, .pwr_fail_i, .acc_i, .wr_i, .addr_i,
    .wdata_i, .rdata_o, .chg_en_o, .chg_diode_o, .chg_res_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1;
      @(negedge clk);
      tick_i = 0;
      if (!m_ctrl[7]) begin
        m_pre++;
        if (m_pre == SEC) begin m_pre = 0; m_cnt++; end
      end
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    acc_i = 1; wr_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk);
    acc_i = 0; wr_i = 0;
    if (!pwr_fail_i) begin
      if (a < 4) begin m_cnt[a*8 +: 8] = d; m_pre = 0; end
      else if (a == 4) m_ctrl = d;
      else if (a == 5) m_trk = d;
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    if (pwr_fail_i) return 8'h00;
    case (a)
      0: return m_cnt[7:0];
      1, 2, 3: return m_snap[(a-1)*8 +: 8];
      4: return m_ctrl;
      5: return m_trk;
      default: return 8'h00;
    endcase
  endfunction

  task automatic rd_chk(input string req, input logic [2:0] a);
    logic [7:0] e;
    e = exp_rd(a);
    acc_i = 1; wr_i = 0; addr_i = a;
    @(negedge clk);
    acc_i = 0;
    if (!pwr_fail_i && a == 0) m_snap = m_cnt[31:8];
    chk(req, rdata_o, e);
  endtask

  task automatic cnt_chk(input string req);
    for (int a = 0; a < 4; a++) rd_chk(req, 3'(a));
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R6 reset state
    chk("R6 rdata", rdata_o, 0);
    chk("R6 chg_en", chg_en_o, 0);
    for (int a = 0; a < 6; a++) rd_chk("R6 reg", 3'(a));

    // R1 counting
    tick(3 * SEC + 5);
    cnt_chk("R1 count 3s");
    chk("R1 explicit", m_cnt, 3);
    tick(3);
    cnt_chk("R1 count 4s");

    // R2 byte map and carry
    wr(0, 8'h78); wr(1, 8'h56); wr(2, 8'h34); wr(3, 8'h12);
    cnt_chk("R2 byte map");
    chk("R2 model", m_cnt, 32'h12345678);
    wr(0, 8'hFF); wr(1, 8'hFF); wr(2, 8'hFF); wr(3, 8'h00);
    tick(SEC);
    cnt_chk("R1 full carry");
    chk("R1 carry model", m_cnt, 32'h01000000);

    // R5 prescaler clear on counter write
    tick(5);
    wr(2, 8'h22);
    tick(SEC - 1);
    cnt_chk("R5 no early inc");
    tick(1);
    cnt_chk("R5 inc after full second");

    // R3 oscillator disable
    tick(3);
    wr(4, 8'h80);
    tick(20);
    cnt_chk("R3 held");
    rd_chk("R3 ctrl readback", 4);
    wr(4, 8'h00);
    tick(SEC - 4);
    cnt_chk("R3 resume phase");

    // R4 snapshot
    wr(0, 8'hFF); wr(1, 8'h00); wr(2, 8'h00); wr(3, 8'h00);
    tick(SEC - 1);
    rd_chk("R4 live low", 0);
    tick(1);
    rd_chk("R4 snap byte1", 1);
    chk("R4 snap explicit", rdata_o, 8'h00);
    rd_chk("R4 new low", 0);
    rd_chk("R4 new byte1", 1);
    chk("R4 new explicit", rdata_o, 8'h01);

    // R7 exhaustive trickle decode
    for (int v = 0; v < 256; v++) begin
      logic [7:0] t;
      logic e;
      t = 8'(v);
      wr(5, t);
      e = (t[7:4] == 4'hA) && (t[3:2] == 2'b01 || t[3:2] == 2'b10) && (t[1:0] != 0);
      chk("R7 en", chg_en_o, e);
      chk("R7 diode", chg_diode_o, t[3:2] == 2'b10);
      chk("R7 res", chg_res_o, t[1:0]);
    end
    wr(5, 8'h00);

    // R8 power-fail lockout
    wr(4, 8'h15);
    pwr_fail_i = 1;
    wr(0, 8'hAA); wr(4, 8'h80); wr(5, 8'hA9);
    chk("R8 chg stays off", chg_en_o, 0);
    rd_chk("R8 read blocked", 4);
    rd_chk("R8 read blocked cnt", 0);
    tick(SEC);
    pwr_fail_i = 0;
    cnt_chk("R8 count continued");
    rd_chk("R8 ctrl kept", 4);
    rd_chk("R8 trk kept", 5);

    // R9 unmapped addresses
    wr(6, 8'h55); wr(7, 8'h66);
    rd_chk("R9 addr6", 6);
    rd_chk("R9 addr7", 7);
    cnt_chk("R9 cnt untouched");
    rd_chk("R9 ctrl untouched", 4);
    rd_chk("R9 trk untouched", 5);

    // R10 read data hold
    wr(4, 8'h3C);
    rd_chk("R10 ctrl", 4);
    wr(4, 8'h11);
    repeat (3) @(negedge clk);
    chk("R10 hold", rdata_o, 8'h3C);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule